// File: doc/BRIEF.md
# Three-Port Latched Datapath Switch

A 9-bit router joining three bidirectional ports, A, B and C. Data entering any port can be sent to one or both of the other two. A port can also put its own previously captured value back on its pins for self-checking. Every path through the switch passes a storage stage of its own: A into C, B into C, C into A and C into B. Each stage is either transparent, following its input in the same cycle, or holding the last value it captured. Bit 8 is meant as a parity bit. A flip control inverts it on the way from C to A and B, so that a parity error can be forced on purpose.

Each bidirectional pin is modelled as three separate signals: an input vector, an output value and a drive-enable. A port drives only while its active-low output-enable is low. Two selects steer the output multiplexers. `sel_src` picks which of the A-side or B-side stored values feeds C; the same value feeds A and B when `sel_cside` is low. `sel_cside` high connects A and B to their own stages fed from C.

Each storage stage is emulated synchronously. A stage whose hold input is low passes its input straight through, and it captures that input at every rising clock edge. A stage whose hold input is high presents the value captured at the last rising edge at which its hold was low.

Top module: `tri_port_xbar`

## Requirements
- R1: When `rst` is released after at least two rising edges, all four stored values read as zero, so `a_out`, `b_out` and `c_out` are zero while every hold input is high.
- R2: While `hold_ac` is low and `sel_src` is 0, `c_out` equals `a_in` in the same cycle.
- R3: While a hold input is high, its stage presents the input value from the last rising edge at which that hold was low, and later changes of the input do not reach the outputs.
- R4: `sel_src` selects the source of `c_out`: 0 takes the A-to-C stage, 1 takes the B-to-C stage.
- R5: With `sel_cside` = 0, `a_out` and `b_out` both carry the stage chosen by `sel_src`, giving A to B (`sel_src`=0) and B to A (`sel_src`=1).
- R6: With `sel_cside` = 1, `a_out` comes from the C-to-A stage and `b_out` from the C-to-B stage, each stage held or transparent on its own.
- R7: `a_oe`, `b_oe` and `c_oe` are the inverses of `oe_a_n`, `oe_b_n` and `oe_c_n`, each independent of the others. When all three enables are high, no port drives.
- R8: With `par_flip` = 1 and `sel_cside` = 1, bit 8 of `a_out` and `b_out` is inverted relative to the C-side stage value. Bits 0 to 7 are never inverted, and `c_out` is never inverted.
- R9: The flip is applied after the C-side stages, so toggling `par_flip` changes bit 8 of `a_out`/`b_out` in the same cycle, even while those stages hold.
- R10: Readback: with `hold_ac` high, `sel_src`=0 and `sel_cside`=0, `a_out` re-presents the held A value (B likewise with `hold_bc` and `sel_src`=1). C reads back by routing through A: C to A, then A's captured value back to C.
- R11: Loop hazard: a port must never drive while its own stage is transparent and that stage feeds the port's own output (A: `a_oe`, `sel_cside`=0, `sel_src`=0, `hold_ac` low; B: `b_oe`, `sel_cside`=0, `sel_src`=1, `hold_bc` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stage capture registers |
| rst | input | 1 | Synchronous active-high reset, clears stored values |
| a_in | input | 9 | Value seen on port A pins |
| b_in | input | 9 | Value seen on port B pins |
| c_in | input | 9 | Value seen on port C pins |
| oe_a_n | input | 1 | Port A output enable, active low |
| oe_b_n | input | 1 | Port B output enable, active low |
| oe_c_n | input | 1 | Port C output enable, active low |
| hold_ac | input | 1 | A-to-C stage hold (low = transparent) |
| hold_bc | input | 1 | B-to-C stage hold (low = transparent) |
| hold_ca | input | 1 | C-to-A stage hold (low = transparent) |
| hold_cb | input | 1 | C-to-B stage hold (low = transparent) |
| sel_src | input | 1 | 0: A-side stage feeds C; 1: B-side stage |
| sel_cside | input | 1 | 0: A/B take the sel_src value; 1: A/B take C-side stages |
| par_flip | input | 1 | Invert bit 8 on C-to-A and C-to-B paths |
| a_out | output | 9 | Value port A drives |
| a_oe | output | 1 | Port A drive-enable |
| b_out | output | 9 | Value port B drives |
| b_oe | output | 1 | Port B drive-enable |
| c_out | output | 9 | Value port C drives |
| c_oe | output | 1 | Port C drive-enable |

## Verification
The assertions assume that the environment never lets a port drive while a transparent stage carries that port's own value back onto it; the loop-hazard properties state exactly this for A and B. The stimulus keeps to that assumption. Every directed step that enables A or B with `sel_cside` low closes the matching stage first. The random phase forces the relevant hold high whenever its draw would create the loop. The C readback step feeds `a_in` with the value A is driving, which stands in for the shared pins, because the modelled ports do not connect output to input themselves.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int unsigned DATA_W   = 9;
    localparam int unsigned NUM_SIDE = 2;
    localparam int unsigned NUM_PORT = 3;

    // Index of the A and B sides in per-side arrays
    localparam int unsigned SIDE_A = 0;
    localparam int unsigned SIDE_B = 1;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic  drive;
        word_t value;
    } port_drv_t;

    // Invert the top (parity) bit when requested
    function automatic word_t parity_adjust(input word_t w, input logic flip);
        word_t r;
        r = w;
        r[DATA_W-1] = w[DATA_W-1] ^ flip;
        return r;
    endfunction

endpackage

// File: rtl/xbar_path_latch.sv
module xbar_path_latch #(
    parameter int unsigned WIDTH = xbar_pkg::DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] store;

    // Capture every edge while open; keep the last capture while held
    always_ff @(posedge clk) begin
        if (rst) begin
            store <= '0;
        end else if (!hold) begin
            store <= d;
        end
    end

    assign q = hold ? store : d;

endmodule

// File: rtl/xbar_port_drive.sv
module xbar_port_drive
    import xbar_pkg::*;
(
    input  logic      oe_n,
    input  word_t     value,
    output port_drv_t drv
);

    always_comb begin
        drv.drive = ~oe_n;
        drv.value = value;
    end

endmodule

// File: rtl/tri_port_xbar.sv
module tri_port_xbar
    import xbar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [DATA_W-1:0] c_in,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    input  logic              oe_c_n,
    input  logic              hold_ac,
    input  logic              hold_bc,
    input  logic              hold_ca,
    input  logic              hold_cb,
    input  logic              sel_src,
    input  logic              sel_cside,
    input  logic              par_flip,
    output logic [DATA_W-1:0] a_out,
    output logic              a_oe,
    output logic [DATA_W-1:0] b_out,
    output logic              b_oe,
    output logic [DATA_W-1:0] c_out,
    output logic              c_oe
);

    word_t               side_in   [NUM_SIDE];
    word_t               to_c_q    [NUM_SIDE];
    word_t               from_c_q  [NUM_SIDE];
    word_t               side_out  [NUM_SIDE];
    logic [NUM_SIDE-1:0] hold_to_c;
    logic [NUM_SIDE-1:0] hold_from_c;
    word_t               src_bus;

    word_t               port_val  [NUM_PORT];
    logic  [NUM_PORT-1:0] port_oen;
    port_drv_t           port_drv  [NUM_PORT];

    assign side_in[SIDE_A]     = a_in;
    assign side_in[SIDE_B]     = b_in;
    assign hold_to_c[SIDE_A]   = hold_ac;
    assign hold_to_c[SIDE_B]   = hold_bc;
    assign hold_from_c[SIDE_A] = hold_ca;
    assign hold_from_c[SIDE_B] = hold_cb;

    // Source bus: the stored value headed for C, also reused by A/B
    assign src_bus = sel_src ? to_c_q[SIDE_B] : to_c_q[SIDE_A];

    for (genvar g = 0; g < NUM_SIDE; g++) begin : g_side
        xbar_path_latch #(.WIDTH(DATA_W)) u_to_c (
            .clk  (clk),
            .rst  (rst),
            .hold (hold_to_c[g]),
            .d    (side_in[g]),
            .q    (to_c_q[g])
        );

        xbar_path_latch #(.WIDTH(DATA_W)) u_from_c (
            .clk  (clk),
            .rst  (rst),
            .hold (hold_from_c[g]),
            .d    (c_in),
            .q    (from_c_q[g])
        );

        // Parity flip sits after the stage, on the C-to-side path only
        assign side_out[g] = sel_cside ? parity_adjust(from_c_q[g], par_flip)
                                       : src_bus;
    end

    assign port_val[0] = side_out[SIDE_A];
    assign port_val[1] = side_out[SIDE_B];
    assign port_val[2] = src_bus;
    assign port_oen    = {oe_c_n, oe_b_n, oe_a_n};

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        xbar_port_drive u_drv (
            .oe_n  (port_oen[p]),
            .value (port_val[p]),
            .drv   (port_drv[p])
        );
    end

    assign a_out = port_drv[0].value;
    assign a_oe  = port_drv[0].drive;
    assign b_out = port_drv[1].value;
    assign b_oe  = port_drv[1].drive;
    assign c_out = port_drv[2].value;
    assign c_oe  = port_drv[2].drive;

endmodule

// File: rtl/tri_port_xbar_chk.sv
module tri_port_xbar_chk
    import xbar_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] a_in,
    input logic [DATA_W-1:0] b_in,
    input logic [DATA_W-1:0] c_in,
    input logic              hold_ac,
    input logic              hold_bc,
    input logic              hold_ca,
    input logic              hold_cb,
    input logic              sel_src,
    input logic              sel_cside,
    input logic              par_flip,
    input logic [DATA_W-1:0] a_out,
    input logic              a_oe,
    input logic [DATA_W-1:0] b_out,
    input logic              b_oe,
    input logic [DATA_W-1:0] c_out
);

    AST_PASS_A_TO_C: assert property (@(posedge clk) disable iff (rst)
        (!hold_ac && !sel_src) |-> (c_out == a_in)); // R2

    AST_PASS_B_TO_C: assert property (@(posedge clk) disable iff (rst)
        (!hold_bc && sel_src) |-> (c_out == b_in)); // R4

    AST_HOLD_A_TO_C: assert property (@(posedge clk) disable iff (rst)
        (hold_ac && $past(hold_ac) && !sel_src && !$past(sel_src) && !$past(rst))
        |-> $stable(c_out)); // R3

    AST_A_TO_B: assert property (@(posedge clk) disable iff (rst)
        (!sel_cside && !sel_src && !hold_ac) |-> (b_out == a_in)); // R5

    AST_FLIP_TO_A: assert property (@(posedge clk) disable iff (rst)
        (sel_cside && !hold_ca)
        |-> (a_out == {c_in[DATA_W-1] ^ par_flip, c_in[DATA_W-2:0]})); // R8

    AST_FLIP_TO_B: assert property (@(posedge clk) disable iff (rst)
        (sel_cside && !hold_cb)
        |-> (b_out == {c_in[DATA_W-1] ^ par_flip, c_in[DATA_W-2:0]})); // R8

    AST_FLIP_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sel_cside && $past(sel_cside) && hold_ca && $past(hold_ca) && !$past(rst))
        |-> ((a_out[DATA_W-2:0] == $past(a_out[DATA_W-2:0])) &&
             ((a_out[DATA_W-1] ^ $past(a_out[DATA_W-1])) == (par_flip ^ $past(par_flip))))); // R9

    AST_NO_LOOP_A: assert property (@(posedge clk) disable iff (rst)
        !(a_oe && !sel_cside && !sel_src && !hold_ac)); // R11

    AST_NO_LOOP_B: assert property (@(posedge clk) disable iff (rst)
        !(b_oe && !sel_cside && sel_src && !hold_bc)); // R11

endmodule

bind tri_port_xbar tri_port_xbar_chk u_chk (.*);

// File: tb/tri_port_xbar_test.sv
module tri_port_xbar_test;
    import xbar_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    word_t a_in = '0, b_in = '0, c_in = '0;
    logic oe_a_n = 1'b1, oe_b_n = 1'b1, oe_c_n = 1'b1;
    logic hold_ac = 1'b1, hold_bc = 1'b1, hold_ca = 1'b1, hold_cb = 1'b1;
    logic sel_src = 1'b0, sel_cside = 1'b0, par_flip = 1'b0;
    word_t a_out, b_out, c_out;
    logic a_oe, b_oe, c_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_port_xbar uut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .oe_c_n(oe_c_n),
        .hold_ac(hold_ac), .hold_bc(hold_bc), .hold_ca(hold_ca), .hold_cb(hold_cb),
        .sel_src(sel_src), .sel_cside(sel_cside), .par_flip(par_flip),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
        .c_out(c_out), .c_oe(c_oe)
    );

    // Reference stored values per R1/R3: captured on edges while open
    word_t m_ac, m_bc, m_ca, m_cb;
    always @(posedge clk) begin
        if (rst) begin
            m_ac <= '0; m_bc <= '0; m_ca <= '0; m_cb <= '0;
        end else begin
            if (!hold_ac) m_ac <= a_in;
            if (!hold_bc) m_bc <= b_in;
            if (!hold_ca) m_ca <= c_in;
            if (!hold_cb) m_cb <= c_in;
        end
    end

    typedef struct {
        string tag;
        word_t ea, eb, ec;
        logic [2:0] eoe;
    } exp_t;

    exp_t sb_q[$];
    event mon_ev;

    // Monitor: pop expected items and compare with the ports
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (a_out !== it.ea || b_out !== it.eb || c_out !== it.ec ||
                    {c_oe, b_oe, a_oe} !== it.eoe) begin
                    errors++;
                    $display("FAIL %s: a=%h b=%h c=%h oe=%b expected a=%h b=%h c=%h oe=%b",
                             it.tag, a_out, b_out, c_out, {c_oe, b_oe, a_oe},
                             it.ea, it.eb, it.ec, it.eoe);
                end
            end
        end
    end

    // Driver: holds = {ac,bc,ca,cb}; oen = {a,b,c}
    task automatic step(input string tag, input word_t a, input word_t b, input word_t c,
                        input logic [3:0] holds, input logic s0, input logic s1,
                        input logic f, input logic [2:0] oen);
        exp_t it;
        word_t la, lb, lca, lcb, bus;
        @(negedge clk);
        a_in = a; b_in = b; c_in = c;
        {hold_ac, hold_bc, hold_ca, hold_cb} = holds;
        sel_src = s0; sel_cside = s1; par_flip = f;
        {oe_a_n, oe_b_n, oe_c_n} = oen;
        #1;
        la  = hold_ac ? m_ac : a;
        lb  = hold_bc ? m_bc : b;
        lca = hold_ca ? m_ca : c;
        lcb = hold_cb ? m_cb : c;
        bus = s0 ? lb : la;
        it.tag = tag;
        it.ec  = bus;
        it.ea  = s1 ? {lca[DATA_W-1] ^ f, lca[DATA_W-2:0]} : bus;
        it.eb  = s1 ? {lcb[DATA_W-1] ^ f, lcb[DATA_W-2:0]} : bus;
        it.eoe = {~oen[0], ~oen[1], ~oen[2]};
        sb_q.push_back(it);
        ->mon_ev;
    endtask

    function automatic word_t rnd();
        return word_t'($urandom);
    endfunction

    initial begin
        word_t p, q;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: stored values cleared by reset
        step("R1", rnd(), rnd(), rnd(), 4'b1111, 1'b0, 1'b0, 1'b0, 3'b111);
        step("R1", rnd(), rnd(), rnd(), 4'b1111, 1'b1, 1'b1, 1'b0, 3'b111);

        // R2: A to C transparent
        for (int i = 0; i < 4; i++)
            step("R2", rnd(), rnd(), rnd(), 4'b0111, 1'b0, 1'b0, 1'b0, 3'b110);

        // R3: close A-to-C, later changes of a_in ignored
        step("R3", rnd(), rnd(), rnd(), 4'b1111, 1'b0, 1'b0, 1'b0, 3'b110);
        step("R3", rnd(), rnd(), rnd(), 4'b1111, 1'b0, 1'b0, 1'b0, 3'b110);

        // R4: B to C transparent then held
        step("R4", rnd(), rnd(), rnd(), 4'b1011, 1'b1, 1'b0, 1'b0, 3'b110);
        step("R4", rnd(), rnd(), rnd(), 4'b1011, 1'b1, 1'b0, 1'b0, 3'b110);
        step("R4", rnd(), rnd(), rnd(), 4'b1111, 1'b1, 1'b0, 1'b0, 3'b110);

        // R5: A to B, A to B+C, B to A
        step("R5", rnd(), rnd(), rnd(), 4'b0111, 1'b0, 1'b0, 1'b0, 3'b101);
        step("R5", rnd(), rnd(), rnd(), 4'b0111, 1'b0, 1'b0, 1'b0, 3'b100);
        step("R5", rnd(), rnd(), rnd(), 4'b1011, 1'b1, 1'b0, 1'b0, 3'b011);

        // R6: C to A, C to B, C to A+B, then held
        step("R6", rnd(), rnd(), rnd(), 4'b1101, 1'b0, 1'b1, 1'b0, 3'b011);
        step("R6", rnd(), rnd(), rnd(), 4'b1110, 1'b0, 1'b1, 1'b0, 3'b101);
        step("R6", rnd(), rnd(), rnd(), 4'b1100, 1'b1, 1'b1, 1'b0, 3'b001);
        step("R6", rnd(), rnd(), rnd(), 4'b1111, 1'b1, 1'b1, 1'b0, 3'b001);

        // R7: enables independent, all released
        step("R7", rnd(), rnd(), rnd(), 4'b1111, 1'b0, 1'b1, 1'b0, 3'b111);
        step("R7", rnd(), rnd(), rnd(), 4'b1111, 1'b0, 1'b1, 1'b0, 3'b010);

        // R8: bit 8 flipped toward A/B only; paths into C untouched
        step("R8", rnd(), rnd(), 9'h100, 4'b1100, 1'b0, 1'b1, 1'b1, 3'b001);
        step("R8", rnd(), rnd(), 9'h0ff, 4'b1100, 1'b0, 1'b1, 1'b1, 3'b001);
        step("R8", 9'h1a5, rnd(), rnd(), 4'b0111, 1'b0, 1'b1, 1'b1, 3'b110);

        // R9: toggle flip while C-side stages hold
        step("R9", rnd(), rnd(), rnd(), 4'b1111, 1'b0, 1'b1, 1'b0, 3'b001);
        step("R9", rnd(), rnd(), rnd(), 4'b1111, 1'b0, 1'b1, 1'b1, 3'b001);
        step("R9", rnd(), rnd(), rnd(), 4'b1111, 1'b0, 1'b1, 1'b0, 3'b001);

        // R10: readback of A, of B, and of C through A (hazard rule R11 kept)
        p = rnd();
        step("R10", p, rnd(), rnd(), 4'b0111, 1'b0, 1'b0, 1'b0, 3'b111);
        step("R10", rnd(), rnd(), rnd(), 4'b1111, 1'b0, 1'b0, 1'b0, 3'b011);
        step("R10", rnd(), rnd(), rnd(), 4'b1111, 1'b0, 1'b0, 1'b0, 3'b011);
        p = rnd();
        step("R10", rnd(), p, rnd(), 4'b1011, 1'b1, 1'b0, 1'b0, 3'b111);
        step("R10", rnd(), rnd(), rnd(), 4'b1111, 1'b1, 1'b0, 1'b0, 3'b101);
        q = rnd();
        step("R10", rnd(), rnd(), q, 4'b1101, 1'b0, 1'b1, 1'b0, 3'b011);
        step("R10", q, rnd(), rnd(), 4'b0111, 1'b0, 1'b1, 1'b0, 3'b011);
        step("R10", rnd(), rnd(), rnd(), 4'b1111, 1'b0, 1'b1, 1'b0, 3'b110);

        // Random walk, keeping to the R11 hazard rule
        for (int i = 0; i < 300; i++) begin
            logic [3:0] h;
            logic s0, s1;
            logic [2:0] oen;
            h = 4'($urandom); s0 = 1'($urandom); s1 = 1'($urandom);
            oen = 3'($urandom);
            if (!s1 && !s0 && !oen[2]) h[3] = 1'b1;
            if (!s1 && s0 && !oen[1]) h[2] = 1'b1;
            step("RND", rnd(), rnd(), rnd(), h, s0, s1, 1'($urandom), oen);
        end

        @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule